// File: doc/BRIEF.md
# Page-Granular Range Register Encoder and Decoder

This block does the arithmetic behind a base/mask pair of range registers that tag a power-of-two region of physical memory with a memory type. On its request side it takes a base page number, a size in pages and an 8-bit type. It checks that the region is naturally aligned to its size, then produces the base word and the mask word for storage. Pages are 4 KiB, so both words carry the page number above bit 12. The physical address width is a parameter, and the page number width is twelve bits less.

The alignment check runs one shift per clock. A start pulse is taken only while the block is idle. A one-cycle done strobe then returns the two words with a 2-bit status: accepted, misaligned, or a zero-size request that disables the range.

On its read-back side, a stored word pair is decoded in one cycle back into base page, size in pages and type. A mask whose upper bits are not all ones is repaired, and a fix-up flag marks that case. In the same cycle the stored pair is compared with a wanted pair, with reserved bits ignored, so that a caller can tell whether a rewrite is needed.

Top module: `range_reg_codec`

## Requirements
- R1: On an accepted request (status 0), the base word equals the base page shifted left by 12, with the type in bits 7:0 and bits 11:8 zero.
- R2: On an accepted request, the mask word equals the two's complement negation of the size in pages (page-number width), shifted left by 12, with bit 11 (valid) set and bits 10:0 otherwise zero.
- R3: A request of size zero completes with status 2 (disable), and both words are zero, so the valid bit is clear.
- R4: Let last = base + size - 1. While base bit 0 is 0 and last bit 0 is 1, both are shifted right by one. The request is accepted only if the two are then equal. Otherwise the status is 1 (misaligned) and both words are zero.
- R5: reqBusy is high from the cycle after an accepted start until the done strobe. reqDone rises no more than page-width + 2 cycles after the start was taken.
- R6: A start pulse while reqBusy is high is ignored: it produces no result and does not change the result of the request in flight.
- R7: A decode whose mask word has bit 11 clear returns base 0, size 0, type 0 and no fix-up.
- R8: A decode returns the base page as base word bits above 11, and the type as base word bits 7:0, one cycle after decValid (decDone high).
- R9: On a valid decode, every mask page bit above the highest set bit is forced to one. Holes below the highest set bit are kept. The fix-up flag is raised if this changed the value. The size in pages is the negation of the repaired mask page.
- R10: The base comparison ignores bits 11:8, and the mask comparison ignores bits 10:0. cmpBaseDiff and cmpMaskDiff flag any other differing bit, one cycle after decValid.
- R11: After reset, reqBusy, reqDone and decDone are low and reqErr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqStart | input | 1 | Start an encode request |
| reqBasePage | input | PHYS_W-12 | Requested base page number |
| reqSizePages | input | PHYS_W-12 | Requested size in pages |
| reqType | input | 8 | Requested memory type |
| reqBusy | output | 1 | Alignment check in progress |
| reqDone | output | 1 | One-cycle result strobe |
| reqErr | output | 2 | 0 accepted, 1 misaligned, 2 disable |
| reqBaseWord | output | PHYS_W | Encoded base word |
| reqMaskWord | output | PHYS_W | Encoded mask word |
| decValid | input | 1 | Decode/compare the presented words |
| decBaseWord | input | PHYS_W | Stored base word |
| decMaskWord | input | PHYS_W | Stored mask word |
| cmpWantBase | input | PHYS_W | Wanted base word |
| cmpWantMask | input | PHYS_W | Wanted mask word |
| decDone | output | 1 | Decode result valid |
| decBasePage | output | PHYS_W-12 | Decoded base page |
| decSizePages | output | PHYS_W-12 | Decoded size in pages |
| decType | output | 8 | Decoded type |
| decFixed | output | 1 | Mask was repaired |
| cmpBaseDiff | output | 1 | Base words differ outside reserved bits |
| cmpMaskDiff | output | 1 | Mask words differ outside reserved bits |

## Verification
The bench drives regions that are aligned after many shifts, after none, and one that stops with unequal values. A loop with the wrong exit condition or compare would let the misaligned cases through or reject the aligned ones. It runs the longest legal shift chain and pulses start mid-run, so a controller that re-arms while busy would produce an extra result or corrupt the first. On read-back it feeds a mask with missing upper ones and one with a hole below its top bit. A repair that fills holes, or that never fills the top, would give a wrong size or fix-up flag. Comparisons differ only in reserved bits, or in one bit just above them.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_MISALIGN = 2'd1,
    ERR_DISABLE  = 2'd2
  } err_e;

  typedef struct packed {
    logic load;
    logic shift;
    logic commit;
  } ctl_t;
endpackage

// File: rtl/rbe_ctrl.sv
module rbe_ctrl (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqStart,
  input  logic          stepCond,
  input  logic          zeroHeld,
  output rbe_pkg::ctl_t ctl,
  output logic          busy
);
  typedef enum logic {S_IDLE, S_RUN} state_e;
  state_e state;

  always_comb begin
    ctl.load   = (state == S_IDLE) && reqStart;
    ctl.shift  = (state == S_RUN) && !zeroHeld && stepCond;
    ctl.commit = (state == S_RUN) && (zeroHeld || !stepCond);
  end

  assign busy = (state == S_RUN);

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else if (ctl.load) state <= S_RUN;
    else if (ctl.commit) state <= S_IDLE;
  end
endmodule

// File: rtl/rbe_datapath.sv
module rbe_datapath #(
  parameter int PHYS_W = 36,
  localparam int PN_W = PHYS_W - 12
) (
  input  logic              clk,
  input  logic              rst,
  input  rbe_pkg::ctl_t     ctl,
  input  logic [PN_W-1:0]   reqBasePage,
  input  logic [PN_W-1:0]   reqSizePages,
  input  logic [7:0]        reqType,
  output logic              stepCond,
  output logic              zeroHeld,
  output logic              reqDone,
  output logic [1:0]        reqErr,
  output logic [PHYS_W-1:0] reqBaseWord,
  output logic [PHYS_W-1:0] reqMaskWord,
  input  logic              decValid,
  input  logic [PHYS_W-1:0] decBaseWord,
  input  logic [PHYS_W-1:0] decMaskWord,
  input  logic [PHYS_W-1:0] cmpWantBase,
  input  logic [PHYS_W-1:0] cmpWantMask,
  output logic              decDone,
  output logic [PN_W-1:0]   decBasePage,
  output logic [PN_W-1:0]   decSizePages,
  output logic [7:0]        decType,
  output logic              decFixed,
  output logic              cmpBaseDiff,
  output logic              cmpMaskDiff
);
  import rbe_pkg::*;

  localparam logic [PHYS_W-1:0] BASE_KEEP = ~{{(PHYS_W-12){1'b0}}, 12'hF00};
  localparam logic [PHYS_W-1:0] MASK_KEEP = ~{{(PHYS_W-12){1'b0}}, 12'h7FF};

  // encode side
  logic [PN_W-1:0] bReg, lReg, baseHold, sizeHold, negSize;
  logic [7:0]      typeHold;

  assign stepCond = !bReg[0] && lReg[0];
  assign negSize  = -sizeHold;

  always_ff @(posedge clk) begin
    if (rst) begin
      bReg <= '0; lReg <= '0; baseHold <= '0; sizeHold <= '0;
      typeHold <= '0; zeroHeld <= 1'b0;
    end else if (ctl.load) begin
      bReg     <= reqBasePage;
      lReg     <= reqBasePage + reqSizePages - PN_W'(1);
      baseHold <= reqBasePage;
      sizeHold <= reqSizePages;
      typeHold <= reqType;
      zeroHeld <= (reqSizePages == '0);
    end else if (ctl.shift) begin
      bReg <= bReg >> 1;
      lReg <= lReg >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqDone <= 1'b0; reqErr <= ERR_NONE;
      reqBaseWord <= '0; reqMaskWord <= '0;
    end else begin
      reqDone <= ctl.commit;
      if (ctl.commit) begin
        if (zeroHeld) begin
          reqErr <= ERR_DISABLE;
          reqBaseWord <= '0; reqMaskWord <= '0;
        end else if (bReg == lReg) begin
          reqErr <= ERR_NONE;
          reqBaseWord <= {baseHold, 4'h0, typeHold};
          reqMaskWord <= {negSize, 12'h800};
        end else begin
          reqErr <= ERR_MISALIGN;
          reqBaseWord <= '0; reqMaskWord <= '0;
        end
      end
    end
  end

  // decode side: fill ones above the highest set mask bit
  logic [PN_W-1:0] mPage, repPage;
  logic            anySet;
  assign mPage  = decMaskWord[PHYS_W-1:12];
  assign anySet = |mPage;

  always_comb begin
    logic seenAbove;
    seenAbove = 1'b0;
    for (int i = PN_W - 1; i >= 0; i--) begin
      repPage[i] = mPage[i] | (!seenAbove && anySet);
      seenAbove  = seenAbove | mPage[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decDone <= 1'b0; decBasePage <= '0; decSizePages <= '0; decType <= '0;
      decFixed <= 1'b0; cmpBaseDiff <= 1'b0; cmpMaskDiff <= 1'b0;
    end else begin
      decDone <= decValid;
      if (decValid) begin
        cmpBaseDiff <= |((decBaseWord ^ cmpWantBase) & BASE_KEEP);
        cmpMaskDiff <= |((decMaskWord ^ cmpWantMask) & MASK_KEEP);
        if (decMaskWord[11]) begin
          decBasePage  <= decBaseWord[PHYS_W-1:12];
          decType      <= decBaseWord[7:0];
          decSizePages <= -repPage;
          decFixed     <= (repPage != mPage);
        end else begin
          decBasePage <= '0; decType <= '0; decSizePages <= '0; decFixed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/range_reg_codec.sv
module range_reg_codec #(
  parameter int PHYS_W = 36,
  localparam int PN_W = PHYS_W - 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqStart,
  input  logic [PN_W-1:0]   reqBasePage,
  input  logic [PN_W-1:0]   reqSizePages,
  input  logic [7:0]        reqType,
  output logic              reqBusy,
  output logic              reqDone,
  output logic [1:0]        reqErr,
  output logic [PHYS_W-1:0] reqBaseWord,
  output logic [PHYS_W-1:0] reqMaskWord,
  input  logic              decValid,
  input  logic [PHYS_W-1:0] decBaseWord,
  input  logic [PHYS_W-1:0] decMaskWord,
  input  logic [PHYS_W-1:0] cmpWantBase,
  input  logic [PHYS_W-1:0] cmpWantMask,
  output logic              decDone,
  output logic [PN_W-1:0]   decBasePage,
  output logic [PN_W-1:0]   decSizePages,
  output logic [7:0]        decType,
  output logic              decFixed,
  output logic              cmpBaseDiff,
  output logic              cmpMaskDiff
);
  rbe_pkg::ctl_t ctl;
  logic stepCond, zeroHeld;

  rbe_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqStart(reqStart), .stepCond(stepCond),
    .zeroHeld(zeroHeld), .ctl(ctl), .busy(reqBusy)
  );

  rbe_datapath #(.PHYS_W(PHYS_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .reqBasePage(reqBasePage), .reqSizePages(reqSizePages), .reqType(reqType),
    .stepCond(stepCond), .zeroHeld(zeroHeld),
    .reqDone(reqDone), .reqErr(reqErr), .reqBaseWord(reqBaseWord), .reqMaskWord(reqMaskWord),
    .decValid(decValid), .decBaseWord(decBaseWord), .decMaskWord(decMaskWord),
    .cmpWantBase(cmpWantBase), .cmpWantMask(cmpWantMask),
    .decDone(decDone), .decBasePage(decBasePage), .decSizePages(decSizePages),
    .decType(decType), .decFixed(decFixed),
    .cmpBaseDiff(cmpBaseDiff), .cmpMaskDiff(cmpMaskDiff)
  );
endmodule

// File: rtl/range_reg_codec_chk.sv
module range_reg_codec_chk #(
  parameter int PHYS_W = 36,
  localparam int PN_W = PHYS_W - 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reqBusy,
  input logic              reqDone,
  input logic [1:0]        reqErr,
  input logic [PHYS_W-1:0] reqBaseWord,
  input logic [PHYS_W-1:0] reqMaskWord,
  input logic [PHYS_W-1:0] decMaskWord,
  input logic              decDone,
  input logic [PN_W-1:0]   decBasePage,
  input logic [PN_W-1:0]   decSizePages,
  input logic [7:0]        decType,
  input logic              decFixed
);
  int unsigned busyCnt;
  always_ff @(posedge clk) begin
    if (rst || !reqBusy) busyCnt <= 0;
    else busyCnt <= busyCnt + 1;
  end

  // R2
  mask_valid_bit_chk: assert property (@(posedge clk) disable iff (rst)
    reqDone && reqErr == 2'd0 |-> reqMaskWord[11:0] == 12'h800 && reqBaseWord[11:8] == 4'h0);
  // R3
  disable_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reqDone && reqErr == 2'd2 |-> reqBaseWord == '0 && reqMaskWord == '0);
  // R4
  misalign_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reqDone && reqErr == 2'd1 |-> reqBaseWord == '0 && reqMaskWord == '0);
  // R5
  busy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busyCnt <= PN_W + 1);
  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reqDone |-> $past(reqBusy) && !reqBusy);
  // R7
  invalid_decode_chk: assert property (@(posedge clk) disable iff (rst)
    decDone && !$past(decMaskWord[11]) |-> decSizePages == '0 && decBasePage == '0 && decType == '0 && !decFixed);
  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !reqBusy && !reqDone && !decDone && reqErr == 2'd0);
endmodule

bind range_reg_codec range_reg_codec_chk #(.PHYS_W(PHYS_W)) u_chk (
  .clk(clk), .rst(rst), .reqBusy(reqBusy), .reqDone(reqDone), .reqErr(reqErr),
  .reqBaseWord(reqBaseWord), .reqMaskWord(reqMaskWord), .decMaskWord(decMaskWord),
  .decDone(decDone), .decBasePage(decBasePage), .decSizePages(decSizePages),
  .decType(decType), .decFixed(decFixed)
);

// File: tb/range_reg_codec_tb.sv
`timescale 1ns/1ps
module range_reg_codec_tb;
  localparam int PHYS_W = 36;
  localparam int PN_W = PHYS_W - 12;

  logic clk = 1'b0, rst = 1'b1;
  logic reqStart = 1'b0;
  logic [PN_W-1:0] reqBasePage = '0, reqSizePages = '0;
  logic [7:0] reqType = '0;
  logic reqBusy, reqDone;
  logic [1:0] reqErr;
  logic [PHYS_W-1:0] reqBaseWord, reqMaskWord;
  logic decValid = 1'b0;
  logic [PHYS_W-1:0] decBaseWord = '0, decMaskWord = '0, cmpWantBase = '0, cmpWantMask = '0;
  logic decDone, decFixed, cmpBaseDiff, cmpMaskDiff;
  logic [PN_W-1:0] decBasePage, decSizePages;
  logic [7:0] decType;

  always #2 clk = ~clk;

  range_reg_codec #(.PHYS_W(PHYS_W)) u_dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef logic [2+2*PHYS_W-1:0] encExp_t;
  typedef logic [PN_W*2+8+3-1:0] decExp_t;
  encExp_t encQ[$]; string encTagQ[$];
  decExp_t decQ[$]; string decTagQ[$];

  function automatic encExp_t encModel(logic [PN_W-1:0] b, logic [PN_W-1:0] s, logic [7:0] t);
    logic [PN_W-1:0] x, y, ns;
    if (s == 0) return {2'd2, {PHYS_W{1'b0}}, {PHYS_W{1'b0}}};
    x = b; y = b + s - 1;
    while (x[0] == 1'b0 && y[0] == 1'b1) begin x = x >> 1; y = y >> 1; end
    if (x != y) return {2'd1, {PHYS_W{1'b0}}, {PHYS_W{1'b0}}};
    ns = -s;
    return {2'd0, {b, 12'h000} | {{(PHYS_W-8){1'b0}}, t}, {ns, 12'h000} | PHYS_W'(12'h800)};
  endfunction

  function automatic decExp_t decModel(logic [PHYS_W-1:0] bw, logic [PHYS_W-1:0] mw,
                                       logic [PHYS_W-1:0] wb, logic [PHYS_W-1:0] wm);
    logic [PN_W-1:0] pg, rp, sz, bp;
    logic [7:0] ty;
    logic fx, bd, md;
    int top;
    bd = ((bw ^ wb) & ~PHYS_W'(12'hF00)) != 0;
    md = ((mw ^ wm) & ~PHYS_W'(12'h7FF)) != 0;
    if (!mw[11]) return {{PN_W{1'b0}}, {PN_W{1'b0}}, 8'h00, 1'b0, bd, md};
    pg = mw[PHYS_W-1:12]; rp = pg; top = -1;
    for (int i = 0; i < PN_W; i++) if (pg[i]) top = i;
    if (top >= 0) for (int i = top + 1; i < PN_W; i++) rp[i] = 1'b1;
    fx = (rp != pg); sz = -rp;
    bp = bw[PHYS_W-1:12]; ty = bw[7:0];
    return {bp, sz, ty, fx, bd, md};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic encReq(string tag, logic [PN_W-1:0] b, logic [PN_W-1:0] s, logic [7:0] t);
    @(negedge clk);
    while (reqBusy) @(negedge clk);
    reqStart = 1'b1; reqBasePage = b; reqSizePages = s; reqType = t;
    encQ.push_back(encModel(b, s, t)); encTagQ.push_back(tag);
    @(negedge clk);
    reqStart = 1'b0;
  endtask

  task automatic decReq(string tag, logic [PHYS_W-1:0] bw, logic [PHYS_W-1:0] mw,
                        logic [PHYS_W-1:0] wb, logic [PHYS_W-1:0] wm);
    @(negedge clk);
    decValid = 1'b1; decBaseWord = bw; decMaskWord = mw; cmpWantBase = wb; cmpWantMask = wm;
    decQ.push_back(decModel(bw, mw, wb, wm)); decTagQ.push_back(tag);
    @(negedge clk);
    decValid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && reqDone) begin
      if (encQ.size() == 0) check("R6 unexpected encode result", 128'(reqErr), 128'hdead);
      else check(encTagQ.pop_front(), 128'({reqErr, reqBaseWord, reqMaskWord}), 128'(encQ.pop_front()));
    end
    if (!rst && decDone) begin
      if (decQ.size() == 0) check("R8 unexpected decode result", 128'(decType), 128'hdead);
      else check(decTagQ.pop_front(),
                 128'({decBasePage, decSizePages, decType, decFixed, cmpBaseDiff, cmpMaskDiff}),
                 128'(decQ.pop_front()));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 busy", 128'(reqBusy), 0);
    check("R11 done/decDone", 128'({reqDone, decDone}), 0);
    check("R11 err", 128'(reqErr), 0);

    encReq("R1 aligned 0x100 pages", 24'h000100, 24'h000100, 8'h06);
    encReq("R2 aligned 0x80 pages", 24'h000100, 24'h000080, 8'h01);
    encReq("R4 base not multiple of size", 24'h000080, 24'h000100, 8'h06);
    encReq("R4 non power of two size", 24'h000000, 24'h000003, 8'h00);
    encReq("R1 single page", 24'h000005, 24'h000001, 8'h04);
    encReq("R3 zero size disable", 24'h001234, 24'h000000, 8'h06);
    encReq("R2 top of address space", 24'hFFF000, 24'h001000, 8'h00);

    // R5/R6: longest shift chain with a start pulse while busy
    encReq("R5 long chain", 24'h000000, 24'h800000, 8'h05);
    reqStart = 1'b1; reqBasePage = 24'h000003; reqSizePages = 24'h000000; reqType = 8'h01;
    @(negedge clk);
    reqStart = 1'b0;
    n = 2;
    while (!reqDone && n < 100) begin @(negedge clk); n++; end
    check("R5 latency bound", 128'(n <= PN_W + 2), 1);
    check("R6 busy cleared at done", 128'(reqBusy), 0);

    decReq("R8 contiguous mask", 36'h12345_0006, 36'hFFF00_0800, 36'h12345_0F06, 36'hFFF00_07FF);
    decReq("R9 repair upper ones", 36'h00ABC_0001, 36'h0FF00_0800, 36'h00ABC_0002, 36'hFFF00_0800);
    decReq("R9 hole below top kept", 36'h00000_0004, 36'hF0F00_0800, 36'h00000_0004, 36'hF0F01_0800);
    decReq("R7 valid bit clear", 36'h12345_0006, 36'hFFF00_0000, 36'h00000_0000, 36'hFFF00_0000);
    decReq("R9 zero mask page", 36'h00001_0005, 36'h00000_0800, 36'h00001_0005, 36'h00000_0800);
    decReq("R10 base differs above reserved", 36'h00001_1000, 36'h80000_0800, 36'h00000_1000, 36'h80000_0800);

    n = 0;
    while ((encQ.size() != 0 || decQ.size() != 0) && n < 200) begin @(negedge clk); n++; end
    repeat (5) @(negedge clk);
    check("R6 all results drained", 128'(encQ.size() + decQ.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule